// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for every beat of a four-beat burst. A load strobe captures a full external address; the two low bits of that address become the burst's starting offset. Each advance strobe then steps only those two low bits, in one of two orders. In linear order the bits count up modulo four from the starting offset. In interleaved order they equal the starting offset XOR the number of beats taken so far. The upper bits stay fixed for the whole burst.

The order input is treated as static. It is captured at each load and is not sampled again until the next load. A clock enable, active high, freezes all state while it is low. The block reports the current full address and the beat index (0 to 3) of the current beat. It is meant to sit between a command decoder, which raises load for a new address and advance for a continue-burst cycle of either a read or a write, and a storage array.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is all zeros and `beat_o` is 0.
- R2: When `clk_en_i`=1 and `load_i`=1 at a rising edge, then after that edge `addr_o` equals `addr_i` and `beat_o` is 0. Load has priority over advance.
- R3: With `order_i`=0 (linear), each advance sets the low two bits of `addr_o` to (previous low bits + 1) mod 4.
- R4: With `order_i`=1 (interleaved), after n advances the low two bits of `addr_o` equal start offset XOR (n mod 4).
- R5: Each advance sets `beat_o` to (previous `beat_o` + 1) mod 4. Advances after the fourth beat keep wrapping inside the same four-address group.
- R6: Advances never change bits above bit 1 of `addr_o`, including when the low bits wrap from 11 back to 00.
- R7: The order used by a burst is the value of `order_i` at its load edge. Changing `order_i` during the burst has no effect on the sequence.
- R8: When `clk_en_i`=0, `addr_o` and `beat_o` hold their values whatever `load_i`, `adv_i` and `addr_i` do.
- R9: When neither load nor advance is asserted, `addr_o` and `beat_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable, active high; when low, all state holds |
| load_i | input | 1 | Capture `addr_i` and start a burst |
| adv_i | input | 1 | Step to the next beat |
| order_i | input | 1 | 0 = linear, 1 = interleaved; captured at load |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | 2 | Index of the current beat |

## Verification
Both outputs come straight from registers. A load or advance presented before a rising edge is therefore visible one cycle later, immediately after that edge, with no further latency. The bench drives its inputs on the falling edge. A behavioural model made of integers updates on the same rising edge, and both the model and the outputs are compared at the next falling edge, which is the first point where the new values are settled. Stall and hold cycles are checked the same way: the outputs must equal the value expected from the previous cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
   localparam int unsigned OFS_W = 2;
endpackage

// File: rtl/burst_ofs_step.sv
module burst_ofs_step
   import burst_seq_pkg::*;
#(
   parameter bit INTERLEAVE = 1'b0
) (
   input  logic [OFS_W-1:0] start_i,
   input  logic [OFS_W-1:0] cur_i,
   input  logic [OFS_W-1:0] next_beat_i,
   output logic [OFS_W-1:0] ofs_o
);
   generate
      if (INTERLEAVE) begin : g_xor
         always_comb ofs_o = start_i ^ next_beat_i;
      end else begin : g_inc
         always_comb ofs_o = cur_i + OFS_W'(1);
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clk_en_i,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic              order_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        beat_o
);
   localparam int unsigned HI_W = ADDR_W - OFS_W;

   initial begin
      if (ADDR_W <= OFS_W) $error("ADDR_W must exceed the offset width");
   end

   logic [HI_W-1:0]  hi_q;
   logic [OFS_W-1:0] ofs_q, start_q, beat_q, beat_nx;
   order_e           ord_q;
   logic [OFS_W-1:0] ofs_lin, ofs_xor, ofs_nx;

   assign beat_nx = beat_q + OFS_W'(1);

   burst_ofs_step #(.INTERLEAVE(1'b0)) u_lin (
      .start_i(start_q), .cur_i(ofs_q), .next_beat_i(beat_nx), .ofs_o(ofs_lin));
   burst_ofs_step #(.INTERLEAVE(1'b1)) u_xor (
      .start_i(start_q), .cur_i(ofs_q), .next_beat_i(beat_nx), .ofs_o(ofs_xor));

   assign ofs_nx = (ord_q == ORD_INTERLEAVE) ? ofs_xor : ofs_lin;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q    <= '0;
         ofs_q   <= '0;
         start_q <= '0;
         beat_q  <= '0;
         ord_q   <= ORD_LINEAR;
      end else if (clk_en_i) begin
         if (load_i) begin
            hi_q    <= addr_i[ADDR_W-1:OFS_W];
            ofs_q   <= addr_i[OFS_W-1:0];
            start_q <= addr_i[OFS_W-1:0];
            beat_q  <= '0;
            ord_q   <= order_e'(order_i);
         end else if (adv_i) begin
            ofs_q  <= ofs_nx;
            beat_q <= beat_nx;
         end
      end
   end

   assign addr_o = {hi_q, ofs_q};
   assign beat_o = beat_q;

   // R8
   stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_en_i |=> ($stable(addr_o) && $stable(beat_o)));
   // R6
   upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_en_i && !load_i && adv_i) |=> $stable(addr_o[ADDR_W-1:OFS_W]));
   // R2
   load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_en_i && load_i) |=> (addr_o == $past(addr_i) && beat_o == 2'd0));
   // R5
   beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_en_i && !load_i && adv_i) |=> (beat_o == 2'($past(beat_o) + 2'd1)));
   // R9
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_en_i && !load_i && !adv_i) |=> $stable(addr_o));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
   localparam int unsigned AW = 20;
   logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, ld = 1'b0, adv = 1'b0, ord = 1'b0;
   logic [AW-1:0] ain = '0;
   logic [AW-1:0] aout;
   logic [1:0] bout;
   int checks = 0, fails = 0;
   int m_hi = 0, m_start = 0, m_ofs = 0, m_beat = 0, m_ord = 0;
   string tag = "R1";

   always #2.5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .clk_en_i(ce), .load_i(ld), .adv_i(adv),
      .order_i(ord), .addr_i(ain), .addr_o(aout), .beat_o(bout));

   always @(posedge clk) begin
      if (rst_n && ce) begin
         if (ld) begin
            m_hi = int'(ain >> 2); m_start = int'(ain & 3); m_ofs = m_start;
            m_beat = 0; m_ord = int'(ord);
         end else if (adv) begin
            m_beat = (m_beat + 1) % 4;
            m_ofs = m_ord ? (m_start ^ m_beat) : (m_ofs + 1) % 4;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic [AW-1:0] exp_a;
         exp_a = AW'(m_hi * 4 + m_ofs);
         checks++;
         if (aout !== exp_a || bout !== 2'(m_beat)) begin
            fails++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, aout, bout, exp_a, m_beat);
         end
      end
   end

   task automatic step(input logic c, input logic l, input logic a,
                       input logic o, input logic [AW-1:0] ad);
      @(negedge clk);
      ce = c; ld = l; adv = a; ord = o; ain = ad;
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      checks++;
      if (aout !== '0 || bout !== 2'd0) begin
         fails++;
         $display("FAIL R1: addr=%h beat=%0d expected 0 0", aout, bout);
      end
      rst_n = 1'b1;
      tag = "R1"; step(1, 0, 0, 0, '0);
      // R2, R3, R5, R6: linear from 01, wrap through 11 -> 00 with high bits kept
      tag = "R2"; step(1, 1, 1, 0, 20'hABCD5);
      tag = "R3_R5_R6";
      for (int i = 0; i < 6; i++) step(1, 0, 1, 0, 20'h00000);
      // R9: idle
      tag = "R9"; step(1, 0, 0, 1, 20'hFFFFF); step(1, 0, 0, 0, 20'h12345);
      // R4: interleaved from 10, R7: order toggled mid-burst
      tag = "R4"; step(1, 1, 0, 1, 20'h7FFFE);
      for (int i = 0; i < 5; i++) step(1, 0, 1, 1, '0);
      tag = "R7";
      for (int i = 0; i < 4; i++) step(1, 0, 1, 0, '0);
      // R8: stall ignores load and advance
      tag = "R8"; step(0, 1, 1, 0, 20'h11111); step(0, 0, 1, 1, 20'h22222);
      step(1, 0, 1, 0, '0);
      // R7: linear load, order raised mid-burst
      tag = "R7"; step(1, 1, 0, 0, 20'h00003);
      for (int i = 0; i < 4; i++) step(1, 0, 1, 1, '0);
      // R4: each interleaved start offset
      tag = "R4";
      for (int s = 0; s < 4; s++) begin
         step(1, 1, 0, 1, AW'(20'h40000 + s));
         for (int i = 0; i < 4; i++) step(1, 0, 1, 1, '0);
      end
      step(1, 0, 0, 0, '0);
      @(negedge clk); @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule